// File: doc/BRIEF.md
# Integration Control with Debug Freeze

This block holds one memory-mapped control word for the system-integration area of a chip. The word decides which supervisory monitors stop while the processor is frozen for debug, how internal bus transfers are made visible on the external bus, and whether external bus arbitration is allowed. It also sets the interrupt-arbitration priority of the block. The freeze input comes from a breakpoint taken while background debug mode is enabled.

Software writes the control word over a simple register bus that carries an address, write data, a write strobe and a flag giving the privilege level of the access. A supervisor-only bit in the word can restrict writes to supervisor accesses. A user-level write that this bit blocks leaves the word unchanged and raises a one-cycle access-error pulse. The monitors, the processor and the interrupt arbiter are separate blocks. They only consume the enables and the decoded bus controls that this block drives.

Top module: `sysint_ctrl`

## Requirements
- R1: With freeze_i high and the freeze-bus bit (control bit 6) set, bus_mon_en_o is 0. In every other case bus_mon_en_o is 1.
- R2: With freeze_i high and the freeze-watchdog bit (control bit 7) set, wdog_en_o and pit_en_o are both 0. In every other case both are 1.
- R3: halt_mon_en_o and spur_mon_en_o stay 1 whatever the values of freeze_i and the control word.
- R4: The show-mode field sits in control bits [5:4]. Code 00 gives show_o=0 and ext_arb_en_o=1. Code 01 gives show_o=1 and ext_arb_en_o=0. Codes 10 and 11 give show_o=1 and ext_arb_en_o=1.
- R5: int_halt_o is 1 only while the show-mode field is 11 and bus_grant_i is 1. It follows bus_grant_i combinationally, so it drops in the same cycle that the grant drops.
- R6: While the supervisor-only bit (control bit 8) is 1, a user-level write (sup_i=0) to the control address leaves the word unchanged. On the next cycle it raises acc_err_o for exactly one cycle.
- R7: A supervisor write to the control address always updates the word. A user write updates it while control bit 8 is 0. Neither of these writes raises acc_err_o.
- R8: Reset gives the control word 0x10F: arbitration priority (bits [3:0]) 1111, show mode 00, both freeze bits 0, supervisor-only bit 1. Reset also gives acc_err_o=0. ctrl_rd_o always presents the word zero-extended, and iarb_o presents bits [3:0].
- R9: A write to any address other than CTRL_ADDR (default 0) leaves the word unchanged and raises no access error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Register bus address |
| wdata_i | input | DW | Register bus write data |
| we_i | input | 1 | Write strobe |
| sup_i | input | 1 | Access is at supervisor level |
| freeze_i | input | 1 | Debug freeze request |
| bus_grant_i | input | 1 | External bus grant |
| ctrl_rd_o | output | DW | Current control word, zero-extended |
| iarb_o | output | 4 | Interrupt-arbitration priority |
| bus_mon_en_o | output | 1 | Bus monitor enable |
| wdog_en_o | output | 1 | Software watchdog enable |
| pit_en_o | output | 1 | Periodic interrupt timer enable |
| halt_mon_en_o | output | 1 | Halt monitor enable |
| spur_mon_en_o | output | 1 | Spurious interrupt monitor enable |
| show_o | output | 1 | Drive internal transfers onto the external bus |
| ext_arb_en_o | output | 1 | External arbitration allowed |
| int_halt_o | output | 1 | Halt internal activity |
| acc_err_o | output | 1 | One-cycle access-error pulse |

## Verification
The assertions check on every cycle that the freeze gating of the bus monitor, the watchdog and the timer follows the freeze bits. They also check that the halt and spurious-interrupt monitors never switch off, that the show-mode decode and the internal-halt term follow the field and the grant, and that a blocked user write leaves the word unchanged and raises the error pulse. Only the bench scenarios can show the reset value of the word and the one-cycle width of the error pulse. The same holds for the acceptance of user writes once protection is cleared, the indifference to foreign addresses, and the drop of internal halt inside the cycle in which the grant falls. The bench shows each of these by driving stand-in monitor counters and the register bus.

// File: rtl/sysint_pkg.sv
package sysint_pkg;
  localparam int IARB_W = 4;

  typedef enum logic [1:0] {
    SHOW_OFF   = 2'b00,
    SHOW_NOARB = 2'b01,
    SHOW_ARB   = 2'b10,
    SHOW_HALT  = 2'b11
  } show_mode_e;

  typedef struct packed {
    logic              sup_only;  // bit 8
    logic              frz_sw;    // bit 7
    logic              frz_bus;   // bit 6
    show_mode_e        show;      // bits 5:4
    logic [IARB_W-1:0] iarb;      // bits 3:0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RST = '{
    sup_only: 1'b1,
    frz_sw:   1'b0,
    frz_bus:  1'b0,
    show:     SHOW_OFF,
    iarb:     {IARB_W{1'b1}}
  };
endpackage

// File: rtl/sysint_regs.sv
module sysint_regs
  import sysint_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  input  logic          sup_i,
  output ctrl_t         ctrl_o,
  output logic          acc_err_o
);
  ctrl_t ctrl_q;
  logic  err_q;
  logic  hit, allowed;

  assign hit     = we_i && (addr_i == CTRL_ADDR);
  assign allowed = sup_i || !ctrl_q.sup_only;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      err_q  <= 1'b0;
    end else begin
      if (hit && allowed) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      err_q <= hit && !allowed;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign acc_err_o = err_q;
endmodule

// File: rtl/sysint_freeze_gate.sv
module sysint_freeze_gate (
  input  logic freeze_i,
  input  logic frz_bus_i,
  input  logic frz_sw_i,
  output logic bus_mon_en_o,
  output logic wdog_en_o,
  output logic pit_en_o,
  output logic halt_mon_en_o,
  output logic spur_mon_en_o
);
  logic sw_stop;

  assign sw_stop       = freeze_i && frz_sw_i;
  assign bus_mon_en_o  = !(freeze_i && frz_bus_i);
  assign wdog_en_o     = !sw_stop;
  assign pit_en_o      = !sw_stop;
  // not subject to freeze
  assign halt_mon_en_o = 1'b1;
  assign spur_mon_en_o = 1'b1;
endmodule

// File: rtl/sysint_show_dec.sv
module sysint_show_dec
  import sysint_pkg::*;
(
  input  show_mode_e mode_i,
  input  logic       bus_grant_i,
  output logic       show_o,
  output logic       ext_arb_en_o,
  output logic       int_halt_o
);
  always_comb begin
    show_o       = 1'b1;
    ext_arb_en_o = 1'b1;
    int_halt_o   = 1'b0;
    unique case (mode_i)
      SHOW_OFF:   show_o       = 1'b0;
      SHOW_NOARB: ext_arb_en_o = 1'b0;
      SHOW_ARB:   ;
      SHOW_HALT:  int_halt_o   = bus_grant_i;
      default:    ;
    endcase
  end
endmodule

// File: rtl/sysint_ctrl.sv
module sysint_ctrl
  import sysint_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              sup_i,
  input  logic              freeze_i,
  input  logic              bus_grant_i,
  output logic [DW-1:0]     ctrl_rd_o,
  output logic [IARB_W-1:0] iarb_o,
  output logic              bus_mon_en_o,
  output logic              wdog_en_o,
  output logic              pit_en_o,
  output logic              halt_mon_en_o,
  output logic              spur_mon_en_o,
  output logic              show_o,
  output logic              ext_arb_en_o,
  output logic              int_halt_o,
  output logic              acc_err_o
);
  localparam int PAD_W = DW - CTRL_W;

  ctrl_t ctrl;

  sysint_regs #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .sup_i,
    .ctrl_o(ctrl), .acc_err_o
  );

  sysint_freeze_gate u_gate (
    .freeze_i,
    .frz_bus_i(ctrl.frz_bus),
    .frz_sw_i (ctrl.frz_sw),
    .bus_mon_en_o, .wdog_en_o, .pit_en_o, .halt_mon_en_o, .spur_mon_en_o
  );

  sysint_show_dec u_show (
    .mode_i(ctrl.show), .bus_grant_i, .show_o, .ext_arb_en_o, .int_halt_o
  );

  assign ctrl_rd_o = {{PAD_W{1'b0}}, ctrl};
  assign iarb_o    = ctrl.iarb;
endmodule

// File: rtl/sysint_chk.sv
module sysint_chk #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter logic [AW-1:0] CTRL_ADDR = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          we_i,
  input logic          sup_i,
  input logic          freeze_i,
  input logic          bus_grant_i,
  input logic [DW-1:0] ctrl_rd_o,
  input logic          bus_mon_en_o,
  input logic          wdog_en_o,
  input logic          pit_en_o,
  input logic          halt_mon_en_o,
  input logic          spur_mon_en_o,
  input logic          show_o,
  input logic          ext_arb_en_o,
  input logic          int_halt_o,
  input logic          acc_err_o
);
  logic frz_bus, frz_sw, sup_only;
  logic [1:0] mode;
  assign frz_bus  = ctrl_rd_o[6];
  assign frz_sw   = ctrl_rd_o[7];
  assign sup_only = ctrl_rd_o[8];
  assign mode     = ctrl_rd_o[5:4];

  assert_bm_gate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_mon_en_o == !(freeze_i && frz_bus));

  assert_sw_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && frz_sw) ? (!wdog_en_o && !pit_en_o) : (wdog_en_o && pit_en_o));

  assert_always_on_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_mon_en_o && spur_mon_en_o);

  assert_show_dec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (show_o == (mode != 2'b00)) && (ext_arb_en_o == (mode != 2'b01)));

  assert_int_halt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_halt_o == ((mode == 2'b11) && bus_grant_i));

  assert_blocked_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == CTRL_ADDR && !sup_i && sup_only)
      |=> (acc_err_o && ctrl_rd_o == $past(ctrl_rd_o)));
endmodule

bind sysint_ctrl sysint_chk #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .sup_i, .freeze_i, .bus_grant_i,
  .ctrl_rd_o, .bus_mon_en_o, .wdog_en_o, .pit_en_o, .halt_mon_en_o,
  .spur_mon_en_o, .show_o, .ext_arb_en_o, .int_halt_o, .acc_err_o
);

// File: tb/sim_sysint_ctrl.sv
module sim_sysint_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic we = 1'b0, sup = 1'b0, freeze = 1'b0, bg = 1'b0;
  logic [DW-1:0] ctrl_rd;
  logic [3:0] iarb;
  logic bm_en, wd_en, pit_en, hm_en, sm_en, show, arb, ihalt, err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysint_ctrl #(.AW(AW), .DW(DW), .CTRL_ADDR('0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .sup_i(sup), .freeze_i(freeze), .bus_grant_i(bg),
    .ctrl_rd_o(ctrl_rd), .iarb_o(iarb), .bus_mon_en_o(bm_en), .wdog_en_o(wd_en),
    .pit_en_o(pit_en), .halt_mon_en_o(hm_en), .spur_mon_en_o(sm_en),
    .show_o(show), .ext_arb_en_o(arb), .int_halt_o(ihalt), .acc_err_o(err)
  );

  // stand-in monitors: down-counters that only move while enabled
  logic [7:0] bm_cnt, wd_cnt, hm_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin bm_cnt <= 8'hFF; wd_cnt <= 8'hFF; hm_cnt <= 8'hFF; end
    else begin
      if (bm_en) bm_cnt <= bm_cnt - 8'd1;
      if (wd_en) wd_cnt <= wd_cnt - 8'd1;
      if (hm_en) hm_cnt <= hm_cnt - 8'd1;
    end
  end

  // control word, {freeze,grant}, expected {bm,wd,pit,show,arb,halt}
  localparam logic [DW-1:0] V_CTRL [NV] = '{16'h10F, 16'h14F, 16'h14F, 16'h18F,
    16'h1DF, 16'h12F, 16'h13F, 16'h13F, 16'h1F5};
  localparam logic [1:0] V_IN [NV] = '{2'b11, 2'b10, 2'b00, 2'b10, 2'b11,
    2'b01, 2'b01, 2'b00, 2'b11};
  localparam logic [5:0] V_EXP [NV] = '{6'b111010, 6'b011010, 6'b111010,
    6'b100010, 6'b000100, 6'b111110, 6'b111111, 6'b111110, 6'b000111};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic s);
    @(negedge clk);
    addr = a; wdata = d; sup = s; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] c0, h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 ctrl", ctrl_rd, 32'h10F);
    check("R8 iarb", iarb, 32'hF);
    check("R8 err", err, 0);
    check("R8 outputs", {bm_en, wd_en, pit_en, show, arb, ihalt}, 6'b111010);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr('0, V_CTRL[i], 1'b1);
      {freeze, bg} = V_IN[i];
      #1;
      check("R1/R2/R4/R5 vector", {bm_en, wd_en, pit_en, show, arb, ihalt}, V_EXP[i]);
      check("R3 always on", {hm_en, sm_en}, 2'b11);
      check("R7 sup write", ctrl_rd, V_CTRL[i]);
    end

    // R1: frozen bus monitor counter holds, halt monitor keeps counting
    wr('0, 16'h14F, 1'b1);
    freeze = 1'b1; bg = 1'b0;
    @(negedge clk); c0 = bm_cnt; h0 = hm_cnt;
    repeat (4) @(negedge clk);
    check("R1 bus monitor counter frozen", bm_cnt, c0);
    check("R3 halt monitor counter runs", hm_cnt, h0 - 8'd4);
    freeze = 1'b0;
    @(negedge clk); c0 = wd_cnt;
    repeat (3) @(negedge clk);
    check("R2 watchdog counter runs unfrozen", wd_cnt, c0 - 8'd3);

    // R5: halt drops in the same cycle the grant drops
    wr('0, 16'h13F, 1'b1);
    bg = 1'b1; #1;
    check("R5 halt with grant", ihalt, 1);
    @(posedge clk); #2; bg = 1'b0; #1;
    check("R5 halt drops with grant", ihalt, 0);

    // R6: blocked user write
    wr('0, 16'h12A, 1'b1);
    @(negedge clk);
    addr = '0; wdata = 16'h000; sup = 1'b0; we = 1'b1;
    @(negedge clk); we = 1'b0;
    check("R6 err pulse", err, 1);
    check("R6 word unchanged", ctrl_rd, 32'h12A);
    @(negedge clk);
    check("R6 err one cycle", err, 0);

    // R9: foreign address ignored
    wr(8'h01, 16'h0C0, 1'b1);
    check("R9 word unchanged", ctrl_rd, 32'h12A);
    check("R9 no err", err, 0);

    // R7: user write accepted once protection cleared
    wr('0, 16'h00F, 1'b1);
    check("R7 clear protection", ctrl_rd, 32'h00F);
    @(negedge clk);
    addr = '0; wdata = 16'h03F; sup = 1'b0; we = 1'b1;
    @(negedge clk); we = 1'b0;
    check("R7 user write accepted", ctrl_rd, 32'h03F);
    check("R7 no err", err, 0);
    check("R7 iarb follows", iarb, 32'hF);

    // R8 again after a second reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 ctrl after reset", ctrl_rd, 32'h10F);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule